// File: doc/BRIEF.md
# Programmable Interval Down-Counter

This block is a single-channel timer. Software loads a start value into a count register and sets a run flag in a control register. The counter then steps down by one on every tick of a divided timer clock. A free-running prescaler makes that tick from the bus clock, and a two-bit divider field picks the division ratio. When the count reaches zero, one of two things happens. In one-shot mode the timer stops, clears its own run flag and latches a sticky "expired" flag. In periodic mode it refills the count from a reload register on the next tick and keeps running.

Software reaches the block over a simple synchronous register bus with an address, separate read and write strobes, write data and combinational read data. Any access to the control register, read or write, clears the sticky expired flag. A read returns the value from before the clear. The block also drives a one-cycle pulse each time the count lands on zero, which a neighbouring interrupt controller can use.

Top module: `ivtimer`

## Requirements
- R1: While the run flag is 1, the count register decreases by exactly one on every timer tick.
- R2: The divider field (control bits 5:4) gives a tick every 1, 2, 4 or 8 bus clocks for the values 0, 1, 2 and 3. The tick comes from a prescaler that runs freely from reset.
- R3: While the run flag is 0, the count register holds its value and ticks have no effect.
- R4: In one-shot mode (control bit 2 = 0), the count stops at zero when it gets there. On that same tick the expired flag (control bit 0) is set and the run flag (control bit 1) is cleared. A tick that finds the count already at zero while running has the same effect.
- R5: In periodic mode (control bit 2 = 1), a tick that finds the count at zero loads the reload register into the count. The run flag stays 1 and the expired flag is not set.
- R6: Output `tc_o` is high for exactly one cycle, in the cycle in which the count register first holds zero after a tick.
- R7: A read or write of the control register (address 0) clears the expired flag. A read returns the flag's value from before the clear.
- R8: A control write ignores bit 0 of the write data. Writing 1 there does not set the expired flag.
- R9: When a control write lands in the same cycle as a one-shot expiry, the expiry decides the result: the run flag ends at 0 and the expired flag ends at 1.
- R10: Reset clears the control register, the count, the reload value and `tc_o`.
- R11: The address map is 0 for control, 1 for count, 2 for reload and 3 for a read-as-zero location. A write to the count wins over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, used only for the clear-on-access side effect |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for the addressed register |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench targets the cycle in which a control write and a one-shot expiry coincide. A design that lets software win would read back a running timer with no expired flag. It checks that a read returns the flag before the clear, and that a later read shows it cleared. A design that is missing either half would return 0 on the first read or keep a stale 1. It measures the latency from start to pulse for every divider value, so a wrong prescaler mask shows up as a cycle count outside the expected window. It also catches periodic-mode errors such as a missing reload, a stopped run flag, or a stop-time tick that goes astray.

// File: rtl/ivtimer_pkg.sv
package ivtimer_pkg;
    localparam int SEL_W = 2;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_COUNT  = 2'd1;
    localparam logic [1:0] A_RELOAD = 2'd2;

    localparam int B_EXPIRED = 0;
    localparam int B_RUN     = 1;
    localparam int B_PERIOD  = 2;
    localparam int B_DIV     = 4;

    typedef struct packed {
        logic             expired;
        logic             run;
        logic             period;
        logic [SEL_W-1:0] div;
    } ctrl_t;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
    import ivtimer_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] div_i,
    output logic             tick_o
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] pre_d, pre_q;
    logic [CW-1:0] mask;

    always_comb begin
        pre_d  = pre_q + CW'(1);
        mask   = ~({CW{1'b1}} << div_i);
        tick_o = ((pre_q & mask) == '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         period_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         pulse_o,
    output logic         stop_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } cstate_t;

    cstate_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        stop_o    = 1'b0;
        if (run_i && tick_i) begin
            if (s_q.cnt == '0) begin
                if (period_i) begin
                    s_d.cnt = reload_i;
                end else begin
                    stop_o    = 1'b1;
                    s_d.pulse = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt - W'(1);
                if (s_q.cnt == W'(1)) begin
                    s_d.pulse = 1'b1;
                    stop_o    = !period_i;
                end
            end
        end
        if (load_i) s_d.cnt = load_val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cnt_o   = s_q.cnt;
    assign pulse_o = s_q.pulse;
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivtimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [1:0]   addr_i,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic [W-1:0] wdata_i,
    input  logic         stop_i,
    input  logic [W-1:0] cnt_i,
    output ctrl_t        ctrl_o,
    output logic [W-1:0] reload_o,
    output logic [W-1:0] rdata_o
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] reload;
    } rstate_t;

    rstate_t s_d, s_q;
    logic    ctrl_hit;

    always_comb begin
        s_d      = s_q;
        ctrl_hit = (rd_i || wr_i) && (addr_i == A_CTRL);
        if (ctrl_hit) s_d.ctrl.expired = 1'b0;
        if (wr_i && addr_i == A_CTRL) begin
            s_d.ctrl.run    = wdata_i[B_RUN];
            s_d.ctrl.period = wdata_i[B_PERIOD];
            s_d.ctrl.div    = wdata_i[B_DIV +: SEL_W];
        end
        if (wr_i && addr_i == A_RELOAD) s_d.reload = wdata_i;
        if (stop_i) begin
            s_d.ctrl.expired = 1'b1;
            s_d.ctrl.run     = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL: begin
                rdata_o[B_EXPIRED]         = s_q.ctrl.expired;
                rdata_o[B_RUN]             = s_q.ctrl.run;
                rdata_o[B_PERIOD]          = s_q.ctrl.period;
                rdata_o[B_DIV +: SEL_W]    = s_q.ctrl.div;
            end
            A_COUNT:  rdata_o = cnt_i;
            A_RELOAD: rdata_o = s_q.reload;
            default:  rdata_o = '0;
        endcase
    end

    assign ctrl_o   = s_q.ctrl;
    assign reload_o = s_q.reload;
endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivtimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [1:0]   addr_i,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         tc_o
);
    ctrl_t            ctrl_q;
    logic             tick;
    logic             stop;
    logic             run_q, period_q, expired_q;
    logic [SEL_W-1:0] div_q;
    logic [W-1:0]     cnt_q, reload_q;

    assign run_q     = ctrl_q.run;
    assign period_q  = ctrl_q.period;
    assign expired_q = ctrl_q.expired;
    assign div_q     = ctrl_q.div;

    ivt_prescaler u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_i  (div_q),
        .tick_o (tick)
    );

    ivt_counter #(.W(W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .run_i      (run_q),
        .period_i   (period_q),
        .load_i     (wr_i && addr_i == A_COUNT),
        .load_val_i (wdata_i),
        .reload_i   (reload_q),
        .cnt_o      (cnt_q),
        .pulse_o    (tc_o),
        .stop_o     (stop)
    );

    ivt_regs #(.W(W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (addr_i),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .wdata_i  (wdata_i),
        .stop_i   (stop),
        .cnt_i    (cnt_q),
        .ctrl_o   (ctrl_q),
        .reload_o (reload_q),
        .rdata_o  (rdata_o)
    );
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
    parameter int W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [1:0]   addr_i,
    input logic         wr_i,
    input logic         rd_i,
    input logic         tick_i,
    input logic         run_i,
    input logic         period_i,
    input logic         expired_i,
    input logic [1:0]   div_i,
    input logic [W-1:0] cnt_i,
    input logic [W-1:0] reload_i,
    input logic         tc_i
);
    logic cnt_wr, ctrl_acc;
    assign cnt_wr   = wr_i && addr_i == 2'd1;
    assign ctrl_acc = (wr_i || rd_i) && addr_i == 2'd0;

    a_r1_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_i && cnt_i != '0 && !cnt_wr) |=> cnt_i == $past(cnt_i) - W'(1));

    a_r2_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_i == 2'd0) |-> tick_i);

    a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !cnt_wr) |=> $stable(cnt_i));

    a_r4_one_shot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_i && cnt_i == W'(1) && !period_i) |=> (!run_i && expired_i));

    a_r5_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_i && cnt_i == '0 && period_i && !cnt_wr) |=> cnt_i == $past(reload_i));

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc_i |=> !tc_i);

    a_r7_access_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_acc |=> (!expired_i || tc_i));

    a_r10_reset_state: assert property (@(posedge clk_i)
        !rst_ni |=> (!run_i && !expired_i && cnt_i == '0 && !tc_i));
endmodule

bind ivtimer ivtimer_chk #(.W(W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .tick_i    (tick),
    .run_i     (run_q),
    .period_i  (period_q),
    .expired_i (expired_q),
    .div_i     (div_q),
    .cnt_i     (cnt_q),
    .reload_i  (reload_q),
    .tc_i      (tc_o)
);

// File: tb/ivtimer_bench.sv
`timescale 1ns/1ps
module ivtimer_bench;
    localparam int W = 16;
    localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
    localparam int NV = 28;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [1:0]   addr_i = '0;
    logic         wr_i = 1'b0, rd_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] rdata_o;
    logic         tc_o;

    int total = 0, fails = 0;
    bit done = 1'b0;

    ivtimer #(.W(W)) u_ivtimer (.*);

    always #2 clk_i = ~clk_i;

    // {op, addr, wdata, expected read, requirement number}
    localparam logic [39:0] VEC [NV] = '{
        {OP_WR, 2'd1, 16'd5,  16'd0,  4'd11},
        {OP_RD, 2'd1, 16'd0,  16'd5,  4'd3},   // R3 stopped, holds
        {OP_RD, 2'd1, 16'd0,  16'd5,  4'd3},
        {OP_WR, 2'd0, 16'h02, 16'd0,  4'd1},
        {OP_RD, 2'd1, 16'd0,  16'd5,  4'd1},   // R1
        {OP_RD, 2'd1, 16'd0,  16'd4,  4'd1},
        {OP_RD, 2'd1, 16'd0,  16'd3,  4'd1},
        {OP_RD, 2'd0, 16'd0,  16'h02, 4'd1},
        {OP_RD, 2'd1, 16'd0,  16'd1,  4'd1},
        {OP_RD, 2'd1, 16'd0,  16'd0,  4'd4},   // R4 stops at zero
        {OP_RD, 2'd0, 16'd0,  16'h01, 4'd4},   // R4 expired, run cleared
        {OP_RD, 2'd0, 16'd0,  16'h00, 4'd7},   // R7 cleared by read
        {OP_WR, 2'd0, 16'h01, 16'd0,  4'd8},
        {OP_RD, 2'd0, 16'd0,  16'h00, 4'd8},   // R8 bit 0 ignored
        {OP_WR, 2'd2, 16'd3,  16'd0,  4'd5},
        {OP_WR, 2'd1, 16'd2,  16'd0,  4'd5},
        {OP_WR, 2'd0, 16'h06, 16'd0,  4'd5},
        {OP_RD, 2'd1, 16'd0,  16'd2,  4'd5},
        {OP_RD, 2'd1, 16'd0,  16'd1,  4'd5},
        {OP_RD, 2'd1, 16'd0,  16'd0,  4'd5},
        {OP_RD, 2'd1, 16'd0,  16'd3,  4'd5},   // R5 refilled
        {OP_RD, 2'd0, 16'd0,  16'h06, 4'd5},   // R5 still running, no flag
        {OP_RD, 2'd1, 16'd0,  16'd1,  4'd5},
        {OP_WR, 2'd0, 16'h00, 16'd0,  4'd3},
        {OP_RD, 2'd1, 16'd0,  16'd3,  4'd3},
        {OP_RD, 2'd1, 16'd0,  16'd3,  4'd3},
        {OP_RD, 2'd2, 16'd0,  16'd3,  4'd11},  // R11 reload readback
        {OP_RD, 2'd3, 16'd0,  16'd0,  4'd11}   // R11 spare address
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] op, input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk_i);
        wr_i = (op == OP_WR);
        rd_i = (op == OP_RD);
        addr_i = a;
        wdata_i = d;
        #1;
    endtask

    initial begin
        #800000;
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        put(OP_RD, 2'd0, '0); check("R10 ctrl after reset", rdata_o, 0);
        put(OP_RD, 2'd1, '0); check("R10 count after reset", rdata_o, 0);
        check("R10 tc after reset", tc_o, 0);

        for (int i = 0; i < NV; i++) begin
            put(VEC[i][39:38], VEC[i][37:36], VEC[i][35:20]);
            if (VEC[i][39:38] == OP_RD)
                check($sformatf("R%0d table row %0d", VEC[i][3:0], i), rdata_o, VEC[i][19:4]);
        end

        // R9: control write in the expiry cycle
        put(OP_WR, 2'd1, 16'd3);
        put(OP_WR, 2'd0, 16'h02);
        put(OP_IDLE, 2'd0, '0);
        put(OP_IDLE, 2'd0, '0);
        put(OP_WR, 2'd0, 16'h02);
        put(OP_RD, 2'd0, '0); check("R9 expiry beats write", rdata_o, 16'h01);
        put(OP_RD, 2'd0, '0); check("R7 cleared after read", rdata_o, 16'h00);

        // R6: pulse timing
        put(OP_WR, 2'd1, 16'd2);
        put(OP_WR, 2'd0, 16'h02);
        put(OP_IDLE, 2'd0, '0); check("R6 no pulse at 2", tc_o, 0);
        put(OP_IDLE, 2'd0, '0); check("R6 no pulse at 1", tc_o, 0);
        put(OP_IDLE, 2'd0, '0); check("R6 pulse at 0", tc_o, 1);
        put(OP_IDLE, 2'd0, '0); check("R6 pulse one cycle", tc_o, 0);
        put(OP_RD, 2'd0, '0);

        // R4: start while already zero
        put(OP_WR, 2'd1, 16'd0);
        put(OP_WR, 2'd0, 16'h02);
        put(OP_IDLE, 2'd0, '0);
        put(OP_RD, 2'd0, '0); check("R4 zero start expires", rdata_o, 16'h01);
        check("R6 zero start pulse", tc_o, 1);

        // R11: count write beats decrement
        put(OP_WR, 2'd1, 16'd20);
        put(OP_WR, 2'd0, 16'h02);
        put(OP_IDLE, 2'd0, '0);
        put(OP_WR, 2'd1, 16'd9);
        put(OP_RD, 2'd1, '0); check("R11 write wins over tick", rdata_o, 9);
        put(OP_RD, 2'd1, '0); check("R1 continues after load", rdata_o, 8);
        put(OP_WR, 2'd0, 16'h00);

        // R2: start-to-pulse latency for each divider
        for (int s = 0; s < 4; s++) begin
            int d;
            d = 1 << s;
            put(OP_WR, 2'd0, 16'h00);
            put(OP_RD, 2'd0, '0);
            put(OP_WR, 2'd1, 16'd4);
            put(OP_WR, 2'd0, 16'(16'h02 | (s << 4)));
            n = 0;
            do begin
                put(OP_IDLE, 2'd0, '0);
                n++;
            end while (!tc_o && n < 50);
            total++;
            if (n < 2 + 3 * d || n > 4 * d + 1) begin
                fails++;
                $display("FAIL R2 divider %0d: actual %0d cycles expected %0d..%0d",
                         s, n, 2 + 3 * d, 4 * d + 1);
            end
        end

        // R10: reset while running
        put(OP_WR, 2'd1, 16'd50);
        put(OP_WR, 2'd0, 16'h02);
        put(OP_IDLE, 2'd0, '0);
        @(negedge clk_i) rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        put(OP_RD, 2'd0, '0); check("R10 ctrl after mid reset", rdata_o, 0);
        put(OP_RD, 2'd1, '0); check("R10 count after mid reset", rdata_o, 0);
        put(OP_RD, 2'd1, '0); check("R10 stays stopped", rdata_o, 0);
        put(OP_IDLE, 2'd0, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule